// File: doc/BRIEF.md
# Stack and Subroutine Sequencer

This block performs all stack traffic of a small 8-bit processor core: saving and restoring the accumulator, the two index registers and the status byte, entering and leaving subroutines, and entering and leaving a software break handler. It keeps the 8-bit stack pointer and the live status flags. It sends one byte at a time to a memory port and loads the program counter when a flow change finishes. The stack lives in a single fixed 256-byte page, and the pointer wraps inside that page.

Each command is accepted in one cycle when the block is idle. Memory commands then perform one access after another; each access waits for its acknowledge. The cycle after the last acknowledge carries a one-cycle `done` pulse along with the results. Register transfers between the stack pointer and X need no memory. They finish with `done` in the cycle after acceptance.

Top module: `stack_seq`

## Requirements
- R1: A push writes to address {0x01, SP} and then decrements SP. A pull first increments SP and then reads {0x01, SP}. SP arithmetic wraps modulo 256 (a push at SP=0x00 leaves SP=0xFF, so the next byte goes to 0x01FF).
- R2: Call (op 0x8) pushes cmd_pc+2 high byte first, then the low byte, and loads pc_out with cmd_target.
- R3: Return from subroutine (op 0x9) pulls the low byte, then the high byte, and loads pc_out with that value plus 1.
- R4: Break (op 0xA) pushes cmd_pc+2 high then low, then the status byte with bit 4 set and the interrupt-disable bit (bit 2) as it was before break. It reads the low byte from 0xFFFE and the high byte from 0xFFFF, loads pc_out with that vector, and sets bit 2.
- R5: Return from interrupt (op 0xB) pulls the status byte, then the low and high PC bytes, and loads pc_out with that value unchanged.
- R6: Pulling status (op 0x7) restores bits 7, 6, 3, 2, 1, 0 (N, V, D, I, Z, C) from the byte. Pulled bits 5 and 4 are ignored: status_out always shows bit 5 = 1 and bit 4 = 0.
- R7: Push A/X/Y (ops 0x0/0x1/0x2) write cmd_data. Push status (op 0x3) writes the status with bits 5 and 4 both set.
- R8: Pull A/X/Y (ops 0x4/0x5/0x6) return the byte on data_out with a data_valid pulse. They set N to bit 7 and Z when the byte is zero, leaving the other flags unchanged.
- R9: Op 0xC presents SP on data_out and sets N and Z from it. Op 0xD loads SP from cmd_data with flags unchanged. Both finish without a memory access, with done in the cycle after acceptance.
- R10: mem_req stays high with stable address, direction and write data until mem_ack. A command offered while busy is ignored.
- R11: After reset SP is 0xFF, status_out is 0x24, pc_out is 0, and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 4 | Command code (see requirements) |
| cmd_pc | input | 16 | Address of the current opcode |
| cmd_target | input | 16 | Call destination |
| cmd_data | input | 8 | Register value to push, or new SP |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | New program counter |
| pc_valid | output | 1 | pc_out loaded this cycle |
| data_out | output | 8 | Pulled register value or SP copy |
| data_valid | output | 1 | data_out loaded this cycle |
| sp_out | output | 8 | Stack pointer |
| status_out | output | 8 | Packed status flags |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |

## Verification
Pushes of ordinary, zero and negative bytes, followed by pulls in reverse order, show whether N and Z follow the pulled byte and whether the order of stack addresses is right. A call and return pair run from SP=0x00 and SP=0x01 crosses the page wrap in both directions. It distinguishes modulo-256 pointer arithmetic from a carry into the page byte, and the +1 on return from a plain reload. Break is entered with interrupt-disable clear, so a pushed status that already has bit 2 set is exposed. Status pulls of 0xFF and 0x00 show that bits 5 and 4 never become live. The memory model stalls 0, 1 or 2 cycles in rotation, and a stray command is offered mid-sequence, so the handshake and busy rules are exercised.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] BRK_VECTOR = 16'hFFFE,
  parameter logic [7:0]  SP_INIT    = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [3:0]  cmd_op,
  input  logic [15:0] cmd_pc,
  input  logic [15:0] cmd_target,
  input  logic [7:0]  cmd_data,
  output logic        busy,
  output logic        done,
  output logic [15:0] pc_out,
  output logic        pc_valid,
  output logic [7:0]  data_out,
  output logic        data_valid,
  output logic [7:0]  sp_out,
  output logic [7:0]  status_out,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic        mem_ack,
  input  logic [7:0]  mem_rdata
);
  localparam logic [3:0] OP_PUSH_A = 4'h0, OP_PUSH_X = 4'h1, OP_PUSH_Y = 4'h2, OP_PUSH_P = 4'h3;
  localparam logic [3:0] OP_PULL_A = 4'h4, OP_PULL_X = 4'h5, OP_PULL_Y = 4'h6, OP_PULL_P = 4'h7;
  localparam logic [3:0] OP_CALL = 4'h8, OP_RET = 4'h9, OP_BREAK = 4'hA, OP_IRET = 4'hB;
  localparam logic [3:0] OP_SP2X = 4'hC, OP_X2SP = 4'hD;
  localparam logic [1:0] D_REG = 2'd0, D_LO = 2'd1, D_HI = 2'd2, D_ST = 2'd3;

  logic [3:0]  op_r;
  logic [2:0]  k;
  logic [15:0] ret_r, tgt_r;
  logic [7:0]  dat_r, lo_r, sp;
  logic        fn, fv, fd, fi, fz, fc;

  logic        step_we, step_vec, step_last;
  logic [7:0]  step_wdata;
  logic [1:0]  dst;
  logic [7:0]  st_push;

  assign st_push    = {fn, fv, 2'b11, fd, fi, fz, fc};
  assign status_out = {fn, fv, 2'b10, fd, fi, fz, fc};
  assign sp_out     = sp;
  assign mem_req    = busy;
  assign mem_we     = busy & step_we;
  assign mem_wdata  = step_wdata;
  assign mem_addr   = step_vec ? (BRK_VECTOR + {15'd0, k == 3'd4})
                               : {STACK_PAGE, step_we ? sp : sp + 8'd1};

  always_comb begin
    step_we = 1'b0; step_vec = 1'b0; step_last = 1'b0;
    step_wdata = 8'h00; dst = D_REG;
    case (op_r)
      OP_PUSH_A, OP_PUSH_X, OP_PUSH_Y: begin
        step_we = 1'b1; step_wdata = dat_r; step_last = 1'b1;
      end
      OP_PUSH_P: begin
        step_we = 1'b1; step_wdata = st_push; step_last = 1'b1;
      end
      OP_PULL_A, OP_PULL_X, OP_PULL_Y: step_last = 1'b1;
      OP_PULL_P: begin dst = D_ST; step_last = 1'b1; end
      OP_CALL: begin
        step_we = 1'b1;
        step_wdata = (k == 3'd0) ? ret_r[15:8] : ret_r[7:0];
        step_last = (k == 3'd1);
      end
      OP_RET: begin
        dst = (k == 3'd0) ? D_LO : D_HI;
        step_last = (k == 3'd1);
      end
      OP_BREAK: begin
        case (k)
          3'd0: begin step_we = 1'b1; step_wdata = ret_r[15:8]; end
          3'd1: begin step_we = 1'b1; step_wdata = ret_r[7:0]; end
          3'd2: begin step_we = 1'b1; step_wdata = st_push; end
          3'd3: begin step_vec = 1'b1; dst = D_LO; end
          default: begin step_vec = 1'b1; dst = D_HI; step_last = 1'b1; end
        endcase
      end
      OP_IRET: begin
        dst = (k == 3'd0) ? D_ST : (k == 3'd1) ? D_LO : D_HI;
        step_last = (k == 3'd2);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; pc_valid <= 1'b0; data_valid <= 1'b0;
      pc_out <= 16'h0000; data_out <= 8'h00; sp <= SP_INIT;
      {fn, fv, fd, fi, fz, fc} <= 6'b000100;
      op_r <= 4'h0; k <= 3'd0; ret_r <= 16'h0000; tgt_r <= 16'h0000;
      dat_r <= 8'h00; lo_r <= 8'h00;
    end else begin
      done <= 1'b0; pc_valid <= 1'b0; data_valid <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          op_r <= cmd_op; k <= 3'd0;
          ret_r <= cmd_pc + 16'd2; tgt_r <= cmd_target; dat_r <= cmd_data;
          case (cmd_op)
            OP_SP2X: begin
              data_out <= sp; data_valid <= 1'b1;
              fn <= sp[7]; fz <= (sp == 8'h00); done <= 1'b1;
            end
            OP_X2SP: begin sp <= cmd_data; done <= 1'b1; end
            OP_PUSH_A, OP_PUSH_X, OP_PUSH_Y, OP_PUSH_P,
            OP_PULL_A, OP_PULL_X, OP_PULL_Y, OP_PULL_P,
            OP_CALL, OP_RET, OP_BREAK, OP_IRET: busy <= 1'b1;
            default: done <= 1'b1;
          endcase
        end
      end else if (mem_ack) begin
        k <= k + 3'd1;
        if (step_we) sp <= sp - 8'd1;
        else if (!step_vec) sp <= sp + 8'd1;
        if (!step_we) begin
          case (dst)
            D_LO: lo_r <= mem_rdata;
            D_HI: begin
              pc_out <= (op_r == OP_RET) ? {mem_rdata, lo_r} + 16'd1 : {mem_rdata, lo_r};
              pc_valid <= 1'b1;
            end
            D_ST: {fn, fv, fd, fi, fz, fc} <= {mem_rdata[7:6], mem_rdata[3:0]};
            default: begin
              data_out <= mem_rdata; data_valid <= 1'b1;
              fn <= mem_rdata[7]; fz <= (mem_rdata == 8'h00);
            end
          endcase
        end
        if (step_last) begin
          busy <= 1'b0; done <= 1'b1;
          if (op_r == OP_CALL) begin pc_out <= tgt_r; pc_valid <= 1'b1; end
          if (op_r == OP_BREAK) fi <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [7:0]  sp_out,
  input logic [7:0]  status_out,
  input logic        mem_req,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic        mem_ack
);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  a_r1_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_addr == {STACK_PAGE, sp_out});
  a_r1_pull_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_addr[15:8] == STACK_PAGE |-> mem_addr[7:0] == sp_out + 8'd1);
  a_r1_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_we |=> sp_out == $past(sp_out) - 8'd1);
  a_r6_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    status_out[5:4] == 2'b10);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind stack_seq stack_seq_chk #(.STACK_PAGE(STACK_PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .sp_out(sp_out),
  .status_out(status_out), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/stack_seq_tb.sv
`timescale 1ns/1ps
module stack_seq_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, cmd_valid = 1'b0;
  logic [3:0] cmd_op = 4'h0;
  logic [15:0] cmd_pc = 16'h0, cmd_target = 16'h0;
  logic [7:0] cmd_data = 8'h0;
  logic busy, done, pc_valid, data_valid, mem_req, mem_we;
  logic [15:0] pc_out, mem_addr;
  logic [7:0] data_out, sp_out, status_out, mem_wdata;
  logic mem_ack = 1'b0;
  logic [7:0] mem_rdata = 8'h00;

  stack_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pc(cmd_pc), .cmd_target(cmd_target), .cmd_data(cmd_data),
    .busy(busy), .done(done), .pc_out(pc_out), .pc_valid(pc_valid),
    .data_out(data_out), .data_valid(data_valid), .sp_out(sp_out),
    .status_out(status_out), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  logic [7:0] mem [logic [15:0]];
  logic [15:0] exp_wa [$];
  logic [7:0]  exp_wd [$];
  int n_chk = 0, n_fail = 0;
  int lat = 0, pat = 0;
  logic [7:0] m_sp = 8'hFF, m_st = 8'h24;

  function automatic logic [7:0] rd(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // memory model with rotating 0/1/2-cycle stalls; checks every write (R1, R2, R4, R7)
  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (lat > 0) lat--;
      else begin
        mem_ack <= 1'b1;
        pat = (pat + 1) % 3;
        lat = pat;
        if (mem_we) begin
          if (exp_wa.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R1 unexpected write: got %0h=%0h expected none", mem_addr, mem_wdata);
          end else begin
            chk("R1 write address", mem_addr, exp_wa.pop_front());
            chk("R7 write data", mem_wdata, exp_wd.pop_front());
          end
          mem[mem_addr] = mem_wdata;
        end else mem_rdata <= rd(mem_addr);
      end
    end
  end

  task automatic push(input logic [7:0] v);
    exp_wa.push_back({8'h01, m_sp});
    exp_wd.push_back(v);
    m_sp = m_sp - 8'd1;
  endtask

  function automatic logic [7:0] pull();
    m_sp = m_sp + 8'd1;
    return rd({8'h01, m_sp});
  endfunction

  task automatic run(input logic [3:0] op, input logic [15:0] pc, input logic [15:0] tgt,
                     input logic [7:0] d, input string tag, input bit stray);
    logic [15:0] r, epc;
    logic [7:0] v, lo, hi, edat;
    bit epv, edv;
    int cyc;
    epv = 0; edv = 0; epc = 16'h0; edat = 8'h0; r = pc + 16'd2;
    case (op)
      4'h0, 4'h1, 4'h2: push(d);
      4'h3: push(m_st | 8'h30);
      4'h4, 4'h5, 4'h6: begin
        v = pull(); edat = v; edv = 1;
        m_st[7] = v[7]; m_st[1] = (v == 8'h00);
      end
      4'h7: begin v = pull(); m_st = (v & 8'hCF) | 8'h20; end
      4'h8: begin push(r[15:8]); push(r[7:0]); epc = tgt; epv = 1; end
      4'h9: begin lo = pull(); hi = pull(); epc = {hi, lo} + 16'd1; epv = 1; end
      4'hA: begin
        push(r[15:8]); push(r[7:0]); push(m_st | 8'h30);
        epc = {rd(16'hFFFF), rd(16'hFFFE)}; epv = 1; m_st[2] = 1'b1;
      end
      4'hB: begin
        v = pull(); m_st = (v & 8'hCF) | 8'h20;
        lo = pull(); hi = pull(); epc = {hi, lo}; epv = 1;
      end
      4'hC: begin edat = m_sp; edv = 1; m_st[7] = m_sp[7]; m_st[1] = (m_sp == 8'h00); end
      default: m_sp = d;
    endcase
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_pc = pc; cmd_target = tgt; cmd_data = d;
    @(negedge clk);
    if (stray) begin
      chk("R10 busy during sequence", busy, 1);
      cmd_op = 4'hD; cmd_data = 8'h77;
    end else cmd_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL %s: got no done expected done", tag);
    end else begin
      chk({tag, " sp"}, sp_out, m_sp);
      chk({tag, " status"}, status_out, m_st);
      chk({tag, " pc_valid"}, pc_valid, epv);
      if (epv) chk({tag, " pc"}, pc_out, epc);
      chk({tag, " data_valid"}, data_valid, edv);
      if (edv) chk({tag, " data"}, data_out, edat);
      chk({tag, " pending writes"}, exp_wa.size(), 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset sp", sp_out, 8'hFF);
    chk("R11 reset status", status_out, 8'h24);
    chk("R11 reset pc", pc_out, 16'h0);
    chk("R11 reset req", mem_req, 0);

    run(4'h0, 0, 0, 8'h5A, "R7 push A", 0);
    run(4'h1, 0, 0, 8'h00, "R7 push X", 0);
    run(4'h2, 0, 0, 8'h80, "R7 push Y", 0);
    run(4'h6, 0, 0, 0, "R8 pull Y negative", 0);
    run(4'h5, 0, 0, 0, "R8 pull X zero", 0);
    run(4'h4, 0, 0, 0, "R8 pull A", 0);
    run(4'h3, 0, 0, 0, "R7 push status", 0);
    run(4'h7, 0, 0, 0, "R6 pull status back", 0);
    mem[{8'h01, m_sp + 8'd1}] = 8'hFF;
    run(4'h7, 0, 0, 0, "R6 pull status FF", 0);
    mem[{8'h01, m_sp + 8'd1}] = 8'h00;
    run(4'h7, 0, 0, 0, "R6 pull status 00", 0);

    run(4'h8, 16'h1234, 16'h4000, 0, "R2 call", 1);
    run(4'h9, 0, 0, 0, "R3 return", 0);

    mem[16'hFFFE] = 8'h10; mem[16'hFFFF] = 8'hC0;
    run(4'hA, 16'h2000, 0, 0, "R4 break", 0);
    run(4'hB, 0, 0, 0, "R5 return from interrupt", 0);

    run(4'hD, 0, 0, 8'h01, "R9 set sp", 0);
    run(4'h8, 16'h0ABC, 16'h5000, 0, "R1 call at sp 01", 0);
    run(4'h9, 0, 0, 0, "R3 return at sp FF", 0);
    run(4'hD, 0, 0, 8'h00, "R9 set sp zero", 0);
    run(4'hC, 0, 0, 0, "R9 read sp zero", 0);
    run(4'h8, 16'hFFFE, 16'h6000, 0, "R1 call wrap", 0);
    run(4'hC, 0, 0, 0, "R9 read sp after wrap", 0);
    run(4'h9, 0, 0, 0, "R1 return wrap", 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule